// File: doc/BRIEF.md
# Auxiliary Channel Request Buffer

This block holds one request and its reply for a display auxiliary channel. Software fills it one byte at a time through a single data register. It writes a four-byte request header and, for a write request, the payload bytes. A separate transfer-control register then starts the transaction, and a bit in that register picks native or I2C mode. The block checks the header against the size limit for that mode. It streams the buffered bytes to the far-end link. It collects the reply bytes back into the same buffer, starting at index zero, and then takes an end code from the link.

A single byte pointer serves both directions. Each access to the data register advances it by one. A flag bit in a data write sets it back to zero. Completion and error events land in a sticky status register that software clears by writing ones, and an interrupt output reports whether any status bit is set. A channel-control register provides an enable and a soft reset. The far-end link is a plain byte-stream port with a valid/ready output side and a valid input side.

Register addresses: 0 data, 1 transfer control, 2 status, 3 channel control. A read returns its value on `reg_rdata` in the cycle after the read strobe.

Top module: `aux_req_buf`

## Requirements
- R1: A write to the data register stores `reg_wdata[7:0]` at the pointer and then advances the pointer by one. If bit 31 is set, the pointer goes to zero before the byte is stored. If bits 31 and 30 are both set, the pointer goes to zero and no byte is stored.
- R2: A read of the data register returns the byte at the pointer in `reg_rdata[15:8]` one cycle later, with the other bits zero, and advances the pointer by one.
- R3: The header is decoded as follows. Byte 0 bit 4 = 1 means a read request, and byte 3 holds the length minus one. The length limit is 16 in native mode and 128 in I2C mode. When GO is written with a length over the limit, status bit 7 is set and no transaction starts.
- R4: Writing the transfer-control register with bit 0 (GO) set while the channel is enabled and idle starts a transaction in the mode given by bit 1 (1 = I2C), which `link_i2c` reports. The block streams the 4 header bytes and then, for a write request only, the payload bytes. `tx_last` marks the final byte, and a byte is held while `tx_ready` is low.
- R5: Reply bytes on `rx_valid` are stored from index 0 upward. After the pointer is reset, the first data read returns the reply command byte and the reply data follows it.
- R6: `rx_end` ends the transaction and sets one status bit from `rx_code`. Code 0 sets bit 0 (done). Codes 1 to 6 set bits 1 to 6 (wrong address, timeout, NACK/defer, wrong data count, I2C NACK, I2C defer). Code 7 sets bit 2. Transfer-control read bit 0 (busy) then returns 0.
- R7: Writing the transfer-control register with bit 0 clear during a transaction cancels it. The byte stream stops, busy clears, and no status bit is set.
- R8: Writes to the data register during a transaction change neither the buffer nor the pointer.
- R9: A store that would land past index DEPTH-1 (143) is dropped and sets sticky status bit 8 (overflow). Storing exactly DEPTH bytes does not set it.
- R10: Status bits stay set until a status-register write with a 1 in their position. `irq` is high exactly when any status bit is set, and it changes in the same cycle as the status.
- R11: Channel-control bit 0 (soft reset) clears the pointer, the status, any transaction and the enable. With bit 0 clear, bit 1 sets the enable. A GO written while the channel is disabled does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 transfer control, 2 status, 3 channel control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| link_i2c | output | 1 | Mode of the current request, 1 = I2C |
| tx_valid | output | 1 | Outgoing request byte valid |
| tx_byte | output | 8 | Outgoing request byte |
| tx_last | output | 1 | Marks the final outgoing byte |
| tx_ready | input | 1 | Link accepts the outgoing byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_byte | input | 8 | Reply byte |
| rx_end | input | 1 | Reply complete, end code valid |
| rx_code | input | 3 | End code of the transaction |
| irq | output | 1 | High while any status bit is set |

## Verification
The assertions take some things for granted about the inputs. They assume the link only raises `rx_valid` and `rx_end` once the outgoing stream has finished. They assume a reply and a cancel never arrive in the same cycle. They also assume software writes a fresh header before every GO, because the header checker keeps its own copy of the header bytes as they are written. The stimulus keeps to this: the responder in the bench sends reply bytes only after it has seen `tx_last`, it pulses `rx_end` separately from any register write, and every transaction begins with a pointer-reset header write.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_SHOW,
    SQ_RX
  } seq_state_t;

  localparam int STW      = 9;
  localparam int ST_SIZE  = 7;
  localparam int ST_OVF   = 8;
  localparam int ST_TMO   = 2;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_XFER = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_CHAN = 2'd3;

  function automatic logic [STW-1:0] code_to_bit(input logic [2:0] c);
    logic [STW-1:0] r;
    if (c == 3'd7) r = STW'(1) << ST_TMO;
    else           r = STW'(1) << c;
    return r;
  endfunction

endpackage

// File: rtl/aux_byte_ram.sv
module aux_byte_ram #(
  parameter int DEPTH = 144,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  AST_RAM_ADDR_OK: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr < AW'(DEPTH))); // R9

endmodule

// File: rtl/aux_hdr_chk.sv
module aux_hdr_chk #(
  parameter int DEPTH      = 144,
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128,
  parameter int AW         = $clog2(DEPTH),
  parameter int PW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [AW-1:0] cap_idx,
  input  logic [7:0]    cap_byte,
  input  logic          i2c,
  output logic          hdr_rd,
  output logic          hdr_ok,
  output logic [PW-1:0] send_cnt
);

  localparam int HDR_BYTES = 4;

  logic [7:0] len_m1;
  logic [8:0] len;
  logic [8:0] limit;
  logic [9:0] total;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_rd <= 1'b0;
      len_m1 <= '0;
    end else if (cap_en) begin
      if (cap_idx == AW'(0)) hdr_rd <= cap_byte[4];
      if (cap_idx == AW'(HDR_BYTES - 1)) len_m1 <= cap_byte;
    end
  end

  always_comb begin
    len      = {1'b0, len_m1} + 9'd1;
    limit    = i2c ? 9'(I2C_MAX) : 9'(NATIVE_MAX);
    total    = hdr_rd ? 10'(HDR_BYTES) : 10'(HDR_BYTES) + {1'b0, len};
    hdr_ok   = (len <= limit) && (total <= 10'(DEPTH));
    send_cnt = PW'(total);
  end

endmodule

// File: rtl/aux_xfer_seq.sv
module aux_xfer_seq
  import aux_req_pkg::*;
#(
  parameter int DEPTH = 144,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           cancel,
  input  logic [PW-1:0]  send_cnt,
  input  logic           tx_ready,
  output logic           tx_valid,
  output logic [7:0]     tx_byte,
  output logic           tx_last,
  input  logic           rx_valid,
  input  logic           rx_end,
  input  logic [2:0]     rx_code,
  output logic           ram_re,
  output logic [AW-1:0]  ram_raddr,
  input  logic [7:0]     ram_q,
  output logic           ram_we,
  output logic [AW-1:0]  ram_waddr,
  output logic           rx_ovf,
  output logic [STW-1:0] end_bits,
  output logic           busy
);

  seq_state_t    state;
  logic [PW-1:0] idx;
  logic [PW-1:0] cnt;
  logic          at_end;
  logic          room;

  assign at_end = (idx == cnt - PW'(1));
  assign room   = (idx < PW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      state <= SQ_IDLE;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          cnt   <= send_cnt;
          idx   <= '0;
          state <= SQ_LOAD;
        end
        SQ_LOAD: state <= SQ_SHOW;
        SQ_SHOW: if (tx_ready) begin
          if (at_end) begin
            idx   <= '0;
            state <= SQ_RX;
          end else begin
            idx   <= idx + PW'(1);
            state <= SQ_LOAD;
          end
        end
        SQ_RX: begin
          if (rx_valid && room) idx <= idx + PW'(1);
          if (rx_end) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_re    = (state == SQ_LOAD);
    ram_raddr = AW'(idx);
    tx_valid  = (state == SQ_SHOW);
    tx_byte   = ram_q;
    tx_last   = (state == SQ_SHOW) && at_end;
    ram_we    = (state == SQ_RX) && rx_valid && room;
    ram_waddr = AW'(idx);
    rx_ovf    = (state == SQ_RX) && rx_valid && !room;
    end_bits  = ((state == SQ_RX) && rx_end && !cancel) ? code_to_bit(rx_code) : '0;
    busy      = (state != SQ_IDLE);
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !cancel) |=> (tx_valid && $stable(tx_byte))); // R4

  AST_RX_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((state == SQ_RX) && rx_end) |=> !busy); // R6

endmodule

// File: rtl/aux_req_buf.sv
module aux_req_buf
  import aux_req_pkg::*;
#(
  parameter int DEPTH      = 144,
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        link_i2c,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_end,
  input  logic [2:0]  rx_code,
  output logic        irq
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0]  ptr;
  logic [STW-1:0] status_q, status_d, set_bits, clr_bits;
  logic           irq_q, chan_en, i2c_q;
  logic [1:0]     sel_q;
  logic [31:0]    hold_q;

  logic wr_data, wr_xfer, wr_stat, wr_chan, rd_data;
  logic soft_rst, ptr_only, busy;
  logic [PW-1:0] base;
  logic sw_store, sw_ovf, sw_read, go_try, start, reject, cancel;

  logic           hdr_rd, hdr_ok;
  logic [PW-1:0]  send_cnt;
  logic           seq_re, seq_we, rx_ovf;
  logic [AW-1:0]  seq_raddr, seq_waddr;
  logic [STW-1:0] end_bits;

  logic           ram_we, ram_re;
  logic [AW-1:0]  ram_waddr, ram_raddr;
  logic [7:0]     ram_wdata, ram_q;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, reg_wdata[29:9]};

  always_comb begin
    wr_data  = reg_wr && (reg_addr == RA_DATA);
    wr_xfer  = reg_wr && (reg_addr == RA_XFER);
    wr_stat  = reg_wr && (reg_addr == RA_STAT);
    wr_chan  = reg_wr && (reg_addr == RA_CHAN);
    rd_data  = reg_rd && (reg_addr == RA_DATA);
    soft_rst = wr_chan && reg_wdata[0];
    ptr_only = reg_wdata[31] && reg_wdata[30];
    base     = reg_wdata[31] ? '0 : ptr;
    sw_store = wr_data && !busy && !ptr_only && (base < PW'(DEPTH));
    sw_ovf   = wr_data && !busy && !ptr_only && (base >= PW'(DEPTH));
    sw_read  = rd_data && !busy && (ptr < PW'(DEPTH));
    go_try   = wr_xfer && reg_wdata[0] && chan_en && !busy;
    start    = go_try && hdr_ok;
    reject   = go_try && !hdr_ok;
    cancel   = (wr_xfer && !reg_wdata[0] && busy) || soft_rst;
  end

  always_comb begin
    set_bits = end_bits;
    set_bits[ST_SIZE] = set_bits[ST_SIZE] | reject;
    set_bits[ST_OVF]  = set_bits[ST_OVF] | sw_ovf | rx_ovf;
    clr_bits = wr_stat ? reg_wdata[STW-1:0] : '0;
    status_d = soft_rst ? '0 : ((status_q & ~clr_bits) | set_bits);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
      chan_en  <= 1'b0;
      i2c_q    <= 1'b0;
      sel_q    <= RA_STAT;
      hold_q   <= '0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
      if (soft_rst) begin
        ptr     <= '0;
        chan_en <= 1'b0;
      end else begin
        if (wr_chan) chan_en <= reg_wdata[1];
        if (wr_data && !busy) begin
          if (ptr_only)               ptr <= '0;
          else if (base < PW'(DEPTH)) ptr <= base + PW'(1);
        end else if (sw_read) begin
          ptr <= ptr + PW'(1);
        end
      end
      if (wr_xfer && !busy) i2c_q <= reg_wdata[1];
      if (reg_rd) begin
        sel_q <= reg_addr;
        unique case (reg_addr)
          RA_STAT: hold_q <= 32'(status_q);
          RA_XFER: hold_q <= {30'b0, i2c_q, busy};
          RA_CHAN: hold_q <= {30'b0, chan_en, 1'b0};
          default: hold_q <= '0;
        endcase
      end
    end
  end

  always_comb begin
    ram_we    = busy ? seq_we    : sw_store;
    ram_waddr = busy ? seq_waddr : AW'(base);
    ram_wdata = busy ? rx_byte   : reg_wdata[7:0];
    ram_re    = busy ? seq_re    : sw_read;
    ram_raddr = busy ? seq_raddr : AW'(ptr);
  end

  assign reg_rdata = (sel_q == RA_DATA) ? {16'b0, ram_q, 8'b0} : hold_q;
  assign irq       = irq_q;
  assign link_i2c  = i2c_q;

  aux_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  aux_hdr_chk #(.DEPTH(DEPTH), .NATIVE_MAX(NATIVE_MAX), .I2C_MAX(I2C_MAX),
                .AW(AW), .PW(PW)) u_hdr (
    .clk(clk), .rst(rst),
    .cap_en(sw_store), .cap_idx(AW'(base)), .cap_byte(reg_wdata[7:0]),
    .i2c(reg_wdata[1]),
    .hdr_rd(hdr_rd), .hdr_ok(hdr_ok), .send_cnt(send_cnt)
  );

  aux_xfer_seq #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_seq (
    .clk(clk), .rst(rst),
    .start(start), .cancel(cancel), .send_cnt(send_cnt),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_end(rx_end), .rx_code(rx_code),
    .ram_re(seq_re), .ram_raddr(seq_raddr), .ram_q(ram_q),
    .ram_we(seq_we), .ram_waddr(seq_waddr),
    .rx_ovf(rx_ovf), .end_bits(end_bits), .busy(busy)
  );

  logic unused_hdr;
  assign unused_hdr = &{1'b0, hdr_rd};

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!wr_stat && !soft_rst) |=> ((status_q & $past(status_q)) == $past(status_q))); // R10

  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (rst)
    reject |=> (!busy && !tx_valid)); // R3

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_data && busy && !soft_rst) |=> $stable(ptr)); // R8

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr <= PW'(DEPTH)); // R9

endmodule

// File: tb/tb_aux_req_buf.sv
module tb_aux_req_buf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        link_i2c, tx_valid, tx_last, irq;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b0, rx_end = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [2:0]  rx_code = '0;

  always #2 clk = ~clk;

  aux_req_buf dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_i2c(link_i2c),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end), .rx_code(rx_code),
    .irq(irq)
  );

  int checks = 0;
  int bad = 0;
  bit reported = 1'b0;

  logic [7:0] exp_tx [0:147];
  logic [7:0] rep_b  [0:147];

  // {i2c, read, addr[19:0], len-1, end code, reject}
  localparam logic [33:0] VEC [8] = '{
    {1'b0, 1'b0, 20'h12345, 8'd15,  3'd0, 1'b0},
    {1'b0, 1'b1, 20'hABCDE, 8'd15,  3'd0, 1'b0},
    {1'b1, 1'b0, 20'h00050, 8'd127, 3'd0, 1'b0},
    {1'b0, 1'b0, 20'h00777, 8'd16,  3'd0, 1'b1},
    {1'b1, 1'b1, 20'h00888, 8'd128, 3'd0, 1'b1},
    {1'b1, 1'b1, 20'h00A50, 8'd2,   3'd5, 1'b0},
    {1'b0, 1'b0, 20'hF0001, 8'd0,   3'd7, 1'b0},
    {1'b0, 1'b1, 20'h00010, 8'd3,   3'd1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] pay(input int s, input int i);
    return 8'((i * 7 + s * 29 + 3) & 255);
  endfunction

  task automatic capture(input int exp_n);
    int n = 0;
    int mism = 0;
    int last_pos = -1;
    for (int k = 0; k < 2000 && last_pos < 0; k++) begin
      @(negedge clk);
      if (tx_valid) begin
        if (tx_byte !== exp_tx[n]) mism++;
        if (tx_last) last_pos = n;
        n++;
      end
    end
    chk("R4 stream byte count", 32'(n), 32'(exp_n));
    chk("R4 stream byte values", 32'(mism), 32'd0);
    chk("R4 last marker position", 32'(last_pos), 32'(exp_n - 1));
  endtask

  task automatic reply(input int n, input logic [2:0] code);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = rep_b[j];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_end = 1'b1; rx_code = code;
    @(negedge clk);
    rx_end = 1'b0;
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic vi2c, vrd, vrej;
    logic [19:0] vaddr;
    logic [7:0]  vlm1, b0;
    logic [2:0]  vcode;
    int len, mism;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(2'd2, d); chk("R10 status after reset", d, 32'h0);
    chk("R10 irq after reset", 32'(irq), 32'h0);
    chk("R4 no stream after reset", 32'(tx_valid), 32'h0);
    rd(2'd1, d); chk("R7 idle after reset", d, 32'h0);

    // GO while disabled
    wr(2'd0, 32'h8000_0001); wr(2'd0, 32'h0); wr(2'd0, 32'h0); wr(2'd0, 32'h0);
    wr(2'd0, 32'h5A);
    wr(2'd1, 32'h1);
    repeat (4) @(negedge clk);
    chk("R11 GO ignored while disabled", 32'(tx_valid), 32'h0);
    rd(2'd1, d); chk("R11 not busy while disabled", d, 32'h0);

    wr(2'd3, 32'h2);
    rd(2'd3, d); chk("R11 enable readback", d, 32'h2);

    // table of transactions
    for (int v = 0; v < 8; v++) begin
      {vi2c, vrd, vaddr, vlm1, vcode, vrej} = VEC[v];
      len = int'(vlm1) + 1;
      b0 = {3'b0, vrd, vaddr[19:16]};
      exp_tx[0] = b0; exp_tx[1] = vaddr[15:8]; exp_tx[2] = vaddr[7:0]; exp_tx[3] = vlm1;
      wr(2'd0, 32'h8000_0000 | 32'(b0));
      wr(2'd0, 32'(vaddr[15:8]));
      wr(2'd0, 32'(vaddr[7:0]));
      wr(2'd0, 32'(vlm1));
      if (!vrd) begin
        for (int j = 0; j < len; j++) begin
          exp_tx[4 + j] = pay(v, j);
          wr(2'd0, 32'(pay(v, j)));
        end
      end
      wr(2'd1, {30'b0, vi2c, 1'b1});
      if (vrej) begin
        repeat (2) @(negedge clk);
        chk("R3 over-limit request not started", 32'(tx_valid), 32'h0);
        rd(2'd2, d); chk("R3 size reject status", d, 32'h80);
        chk("R10 irq on reject", 32'(irq), 32'h1);
        wr(2'd2, 32'h1FF);
      end else begin
        capture(vrd ? 4 : 4 + len);
        chk("R4 mode output", 32'(link_i2c), 32'(vi2c));
        rep_b[0] = 8'hA0 + 8'(v);
        for (int j = 0; j < len; j++) rep_b[j + 1] = pay(v + 50, j);
        reply(vrd ? 1 + len : 1, vcode);
        rd(2'd2, d);
        chk("R6 end status bit", d, (vcode == 3'd7) ? 32'h4 : (32'h1 << vcode));
        chk("R10 irq on end", 32'(irq), 32'h1);
        rd(2'd1, d); chk("R6 not busy after end", d & 32'h1, 32'h0);
        wr(2'd0, 32'hC000_0000);
        rd(2'd0, d); chk("R5 reply command byte", d, {16'b0, rep_b[0], 8'b0});
        if (vrd) begin
          mism = 0;
          for (int j = 0; j < len; j++) begin
            rd(2'd0, d);
            if (d !== {16'b0, rep_b[j + 1], 8'b0}) mism++;
          end
          chk("R5 R2 reply data bytes", 32'(mism), 32'h0);
        end
        wr(2'd2, 32'h1FF);
        rd(2'd2, d); chk("R10 status cleared by write-one", d, 32'h0);
      end
    end

    // stall then cancel
    tx_ready = 1'b0;
    wr(2'd0, 32'h8000_0005); wr(2'd0, 32'h67); wr(2'd0, 32'h89); wr(2'd0, 32'h00);
    wr(2'd0, 32'h3E);
    wr(2'd1, 32'h1);
    repeat (3) @(negedge clk);
    chk("R4 byte offered under stall", 32'(tx_valid), 32'h1);
    chk("R4 first byte under stall", 32'(tx_byte), 32'h05);
    repeat (3) @(negedge clk);
    chk("R4 byte held under stall", 32'(tx_byte), 32'h05);
    wr(2'd1, 32'h0);
    chk("R7 stream stops on cancel", 32'(tx_valid), 32'h0);
    rd(2'd1, d); chk("R7 not busy after cancel", d & 32'h1, 32'h0);
    rd(2'd2, d); chk("R7 no status on cancel", d, 32'h0);
    tx_ready = 1'b1;

    // writes during a transaction are ignored
    wr(2'd0, 32'h8000_0010); wr(2'd0, 32'h3C); wr(2'd0, 32'h55); wr(2'd0, 32'h00);
    exp_tx[0] = 8'h10; exp_tx[1] = 8'h3C; exp_tx[2] = 8'h55; exp_tx[3] = 8'h00;
    wr(2'd1, 32'h1);
    capture(4);
    wr(2'd0, 32'h8000_00EE);
    wr(2'd0, 32'h11);
    rep_b[0] = 8'h77;
    reply(1, 3'd0);
    rd(2'd2, d); chk("R6 done status", d, 32'h1);
    wr(2'd0, 32'hC000_0000);
    rd(2'd0, d); chk("R5 reply at index 0", d, 32'h7700);
    rd(2'd0, d); chk("R8 index 1 untouched while busy", d, 32'h3C00);
    rd(2'd0, d); chk("R8 index 2 untouched while busy", d, 32'h5500);
    wr(2'd2, 32'h1FF);

    // fill to the boundary, then overflow
    wr(2'd0, 32'h8000_0000 | 32'(pay(9, 0)));
    for (int j = 1; j < 144; j++) wr(2'd0, 32'(pay(9, j)));
    rd(2'd2, d); chk("R9 full buffer no overflow", d, 32'h0);
    wr(2'd0, 32'hAB);
    rd(2'd2, d); chk("R9 overflow flag", d, 32'h100);
    chk("R10 irq on overflow", 32'(irq), 32'h1);
    wr(2'd0, 32'hC000_0000);
    mism = 0;
    for (int j = 0; j < 144; j++) begin
      rd(2'd0, d);
      if (d !== {16'b0, pay(9, j), 8'b0}) mism++;
    end
    chk("R1 R2 R9 buffer contents", 32'(mism), 32'h0);
    wr(2'd2, 32'h100);
    rd(2'd2, d); chk("R10 overflow cleared", d, 32'h0);
    chk("R10 irq cleared", 32'(irq), 32'h0);

    // soft reset
    wr(2'd0, 32'h8000_0010); wr(2'd0, 32'h0); wr(2'd0, 32'h0); wr(2'd0, 32'hFF);
    wr(2'd1, 32'h1);
    rd(2'd2, d); chk("R3 native length 256 rejected", d, 32'h80);
    wr(2'd3, 32'h1);
    rd(2'd2, d); chk("R11 soft reset clears status", d, 32'h0);
    chk("R11 soft reset clears irq", 32'(irq), 32'h0);
    rd(2'd3, d); chk("R11 soft reset clears enable", d, 32'h0);
    rd(2'd0, d); chk("R11 soft reset clears pointer", d, 32'h1000);

    summary();
    $finish;
  end

endmodule